// File: doc/BRIEF.md
# DRAM Channel Address Decoder

This block steers each physical memory request to one of the memory channels. Software programs eight range rules through a dword register port. Each rule has an upper bound, an interleave mode and an enable bit. Each rule also has its own table of eight channel numbers. The block looks at a 40-bit request address and picks the first enabled rule whose window holds the address. It derives a 3-bit interleave index from the address in the way that rule's mode asks, and returns the channel stored at that index of the rule's table.

The window of rule i starts at the bound of rule i-1, or at zero for rule 0, and ends just below its own bound. Bounds are compared against the top 14 address bits, so the granularity is 64 MB. Software is expected to program strictly rising bounds. When it does not, the lowest-numbered matching rule wins. An address that matches no rule is not an error: the result is flagged as a miss and the channel is reported as zero.

Top module: `chan_addr_decoder`

## Requirements
- R1: After reset, every rule register and every channel-table register reads zero, all rules are disabled, and every lookup is a miss.
- R2: The rule register of rule i sits at byte offset 0x80+4*i. Its bound is in bits 19:6, its mode in bits 2:1 and its enable in bit 0, and all other bits read zero. The channel table of rule i sits at 0xC0+4*i. Entry k is in bits 2k+1:2k, and bits 31:16 read zero. Any other offset reads zero, and a write to it changes no register.
- R3: Rule i matches when it is enabled and prev <= addr[39:26] < bound_i. Here prev is the bound of rule i-1 whether or not that rule is enabled, and 0 for rule 0.
- R4: When several rules match, the lowest-numbered one decides the result.
- R5: When no rule matches, the result shows hit=0 and channel 0.
- R6: Mode 0 uses the index {addr[8],addr[7],addr[6]}, with addr[8] as the MSB.
- R7: Mode 1 uses the index {addr[8:6]} XOR {addr[18:16]}.
- R8: Mode 2 uses the index {addr[6], addr[39:6] mod 3}, with addr[6] as the MSB.
- R9: Mode 3 is reserved and gives the same index as mode 0.
- R10: A request presented with req_valid high in cycle n shows its result with resp_valid high in cycle n+1. resp_valid is low in every cycle that follows a cycle without a request.
- R11: On a hit, the channel is the table entry of the winning rule selected by the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset (bits 1:0 ignored) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 40 | Physical address to decode |
| resp_valid | output | 1 | Result valid, one cycle after req_valid |
| resp_hit | output | 1 | Some enabled rule matched |
| resp_chan | output | 2 | Selected channel (0 on a miss) |

## Verification
Register reads are combinational. The bench drives cfg_addr on the falling edge and compares cfg_rdata a nanosecond later. A write takes effect at the next rising edge, so it is checked only on a read issued after that edge. Lookup results pass through one register. Each request is driven on a falling edge, and resp_valid, resp_hit and resp_chan are compared on the next falling edge, half a cycle after the capturing edge. The falling edge after that checks that resp_valid has dropped. The bench sweeps every bound slot of two rule layouts with random low address bits and computes each expected channel arithmetically, with the modulo-3 term taken from the native % operator.

// File: rtl/chad_pkg.sv
package chad_pkg;

   // Interleave index source selected per rule
   typedef enum logic [1:0] {
      IMODE_LOW  = 2'b00,
      IMODE_XOR  = 2'b01,
      IMODE_MOD3 = 2'b10,
      IMODE_RSVD = 2'b11
   } imode_e;

endpackage

// File: rtl/chad_mod3.sv
// Residue modulo 3 by folding 2-bit digits (4 == 1 mod 3).
module chad_mod3 #(
   parameter int IN_W = 34
) (
   input  logic [IN_W-1:0] val,
   output logic [1:0]      res
);
   localparam int NGRP  = (IN_W + 1) / 2;
   localparam int PAD_W = 2 * NGRP;

   if (3 * NGRP > 255) begin : g_bad_width
      $error("chad_mod3: IN_W too large for 8-bit digit sum");
   end

   logic [PAD_W-1:0] padded;
   logic [7:0]       s1;
   logic [3:0]       s2;
   logic [2:0]       s3;
   logic [2:0]       s4;

   assign padded = PAD_W'(val);

   always_comb begin
      s1 = '0;
      for (int g = 0; g < NGRP; g++) begin
         s1 = s1 + 8'(padded[2*g +: 2]);
      end
   end

   // <= 12 after first fold, <= 6 after second
   assign s2 = 4'(s1[1:0]) + 4'(s1[3:2]) + 4'(s1[5:4]) + 4'(s1[7:6]);
   assign s3 = 3'(s2[1:0]) + 3'(s2[3:2]);

   always_comb begin
      s4 = (s3 >= 3'd3) ? s3 - 3'd3 : s3;
      if (s4 >= 3'd3) s4 = s4 - 3'd3;
   end

   assign res = s4[1:0];

endmodule

// File: rtl/chad_index_gen.sv
// Interleave index computation for the winning rule's mode.
module chad_index_gen
   import chad_pkg::*;
#(
   parameter int ADDR_W   = 40,
   parameter int LINE_LSB = 6,
   parameter int XOR_LSB  = 16,
   parameter int IDX_W    = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        mode,
   output logic [IDX_W-1:0]  idx,
   output logic [1:0]        residue
);
   localparam int LINE_W = ADDR_W - LINE_LSB;

   if (IDX_W != 3) begin : g_bad_idx
      $error("chad_index_gen: index width must be 3");
   end
   if (XOR_LSB + IDX_W > ADDR_W || LINE_LSB + IDX_W > XOR_LSB) begin : g_bad_pos
      $error("chad_index_gen: bit positions out of range");
   end

   logic [IDX_W-1:0] lo_bits;
   logic [IDX_W-1:0] hi_bits;

   assign lo_bits = addr[LINE_LSB +: IDX_W];
   assign hi_bits = addr[XOR_LSB  +: IDX_W];

   chad_mod3 #(.IN_W(LINE_W)) u_mod3 (
      .val (addr[ADDR_W-1:LINE_LSB]),
      .res (residue)
   );

   always_comb begin
      unique case (imode_e'(mode))
         IMODE_XOR:  idx = lo_bits ^ hi_bits;
         IMODE_MOD3: idx = {addr[LINE_LSB], residue};
         default:    idx = lo_bits;   // low bits and reserved
      endcase
   end

endmodule

// File: rtl/chad_rule_match.sv
// Half-open window compare for one rule.
module chad_rule_match #(
   parameter int KEY_W = 14
) (
   input  logic [KEY_W-1:0] key,
   input  logic [KEY_W-1:0] lo,
   input  logic [KEY_W-1:0] hi,
   input  logic             en,
   output logic             hit
);
   assign hit = en && (key >= lo) && (key < hi);
endmodule

// File: rtl/chad_cfg_regs.sv
// Rule and channel-table registers with a dword access port.
module chad_cfg_regs #(
   parameter int          NUM_RULES = 8,
   parameter int          LIMIT_W   = 14,
   parameter int          LIMIT_LSB = 6,
   parameter int          LIST_BITS = 16,
   parameter int          CFG_AW    = 8,
   parameter logic [31:0] RULE_BASE = 32'h80,
   parameter logic [31:0] LIST_BASE = 32'hC0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cfg_we,
   input  logic [CFG_AW-1:0]                    cfg_addr,
   input  logic [31:0]                          cfg_wdata,
   output logic [31:0]                          cfg_rdata,
   output logic [NUM_RULES-1:0][LIMIT_W-1:0]    rule_limit,
   output logic [NUM_RULES-1:0][1:0]            rule_mode,
   output logic [NUM_RULES-1:0]                 rule_en,
   output logic [NUM_RULES-1:0][LIST_BITS-1:0]  rule_list
);
   localparam int DW_W    = CFG_AW - 2;
   localparam int RULE_DW = int'(RULE_BASE >> 2);
   localparam int LIST_DW = int'(LIST_BASE >> 2);

   if (LIMIT_LSB + LIMIT_W > 32 || LIMIT_LSB < 3) begin : g_bad_limit
      $error("chad_cfg_regs: bound field does not fit");
   end
   if (LIST_BITS > 32) begin : g_bad_list
      $error("chad_cfg_regs: channel table does not fit a dword");
   end

   logic [DW_W-1:0]      dw;
   logic [NUM_RULES-1:0] rule_sel;
   logic [NUM_RULES-1:0] list_sel;

   assign dw = cfg_addr[CFG_AW-1:2];

   for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
      assign rule_sel[i] = (dw == DW_W'(RULE_DW + i));
      assign list_sel[i] = (dw == DW_W'(LIST_DW + i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rule_limit[i] <= '0;
            rule_mode[i]  <= '0;
            rule_en[i]    <= 1'b0;
         end else if (cfg_we && rule_sel[i]) begin
            rule_limit[i] <= cfg_wdata[LIMIT_LSB +: LIMIT_W];
            rule_mode[i]  <= cfg_wdata[2:1];
            rule_en[i]    <= cfg_wdata[0];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rule_list[i] <= '0;
         end else if (cfg_we && list_sel[i]) begin
            rule_list[i] <= cfg_wdata[LIST_BITS-1:0];
         end
      end

      // R2: a write to a rule register lands in its enable bit
      assert_enable_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && rule_sel[i]) |=> (rule_en[i] == $past(cfg_wdata[0])));
      // R2: table registers hold unless addressed
      assert_list_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_we && list_sel[i]) |=> $stable(rule_list[i]));
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_RULES; i++) begin
         if (rule_sel[i]) begin
            cfg_rdata[LIMIT_LSB +: LIMIT_W] = rule_limit[i];
            cfg_rdata[2:1]                  = rule_mode[i];
            cfg_rdata[0]                    = rule_en[i];
         end
         if (list_sel[i]) begin
            cfg_rdata[LIST_BITS-1:0] = rule_list[i];
         end
      end
   end

endmodule

// File: rtl/chan_addr_decoder.sv
// Address-to-channel decoder: range rules, per-rule interleave, one register stage.
module chan_addr_decoder #(
   parameter int          NUM_RULES = 8,
   parameter int          ADDR_W    = 40,
   parameter int          LIMIT_W   = 14,
   parameter int          LIMIT_LSB = 6,
   parameter int          LINE_LSB  = 6,
   parameter int          XOR_LSB   = 16,
   parameter int          IDX_W     = 3,
   parameter int          CHAN_W    = 2,
   parameter int          CFG_AW    = 8,
   parameter logic [31:0] RULE_BASE = 32'h80,
   parameter logic [31:0] LIST_BASE = 32'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [CHAN_W-1:0] resp_chan
);
   localparam int LIST_LEN  = 1 << IDX_W;
   localparam int LIST_BITS = LIST_LEN * CHAN_W;
   localparam int KEY_LSB   = ADDR_W - LIMIT_W;

   if (KEY_LSB <= XOR_LSB + IDX_W - 1) begin : g_bad_key
      $error("chan_addr_decoder: bound bits overlap interleave bits");
   end
   if (NUM_RULES < 1) begin : g_bad_rules
      $error("chan_addr_decoder: need at least one rule");
   end

   logic [NUM_RULES-1:0][LIMIT_W-1:0]   rule_limit;
   logic [NUM_RULES-1:0][1:0]           rule_mode;
   logic [NUM_RULES-1:0]                rule_en;
   logic [NUM_RULES-1:0][LIST_BITS-1:0] rule_list;

   chad_cfg_regs #(
      .NUM_RULES (NUM_RULES),
      .LIMIT_W   (LIMIT_W),
      .LIMIT_LSB (LIMIT_LSB),
      .LIST_BITS (LIST_BITS),
      .CFG_AW    (CFG_AW),
      .RULE_BASE (RULE_BASE),
      .LIST_BASE (LIST_BASE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .rule_limit (rule_limit),
      .rule_mode  (rule_mode),
      .rule_en    (rule_en),
      .rule_list  (rule_list)
   );

   logic [LIMIT_W-1:0]   key;
   logic [NUM_RULES-1:0] match;
   logic [NUM_RULES-1:0] win;

   assign key = req_addr[ADDR_W-1:KEY_LSB];

   for (genvar i = 0; i < NUM_RULES; i++) begin : g_match
      logic [LIMIT_W-1:0] lo;
      if (i == 0) begin : g_first
         assign lo = '0;
      end else begin : g_next
         assign lo = rule_limit[i-1];
      end
      chad_rule_match #(.KEY_W(LIMIT_W)) u_match (
         .key (key),
         .lo  (lo),
         .hi  (rule_limit[i]),
         .en  (rule_en[i]),
         .hit (match[i])
      );
   end

   // Lowest index wins
   always_comb begin
      logic found;
      found = 1'b0;
      win   = '0;
      for (int i = 0; i < NUM_RULES; i++) begin
         if (match[i] && !found) begin
            win[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   logic [1:0]           sel_mode;
   logic [LIST_BITS-1:0] sel_list;

   always_comb begin
      sel_mode = '0;
      sel_list = '0;
      for (int i = 0; i < NUM_RULES; i++) begin
         sel_mode = sel_mode | (rule_mode[i] & {2{win[i]}});
         sel_list = sel_list | (rule_list[i] & {LIST_BITS{win[i]}});
      end
   end

   logic [IDX_W-1:0] idx;
   logic [1:0]       residue;

   chad_index_gen #(
      .ADDR_W   (ADDR_W),
      .LINE_LSB (LINE_LSB),
      .XOR_LSB  (XOR_LSB),
      .IDX_W    (IDX_W)
   ) u_idx (
      .addr    (req_addr),
      .mode    (sel_mode),
      .idx     (idx),
      .residue (residue)
   );

   logic              nxt_hit;
   logic [CHAN_W-1:0] nxt_chan;

   assign nxt_hit  = |match;
   assign nxt_chan = nxt_hit ? sel_list[idx*CHAN_W +: CHAN_W] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_chan  <= '0;
      end else begin
         resp_valid <= req_valid;
         if (req_valid) begin
            resp_hit  <= nxt_hit;
            resp_chan <= nxt_chan;
         end
      end
   end

   // R10: result strobe trails the request by exactly one cycle
   assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);
   assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid);
   // R5: a miss reports channel zero
   assert_miss_chan_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> (resp_chan == '0));
   // R3: with every rule disabled nothing can hit
   assert_disabled_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (rule_en == '0)) |=> !resp_hit);
   // R4: at most one rule decides
   assert_single_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win));
   // R8: residue is always a legal mod-3 value
   assert_mod3_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      residue != 2'b11);

endmodule

// File: tb/chan_addr_decoder_test.sv
`timescale 1ns/1ps
module chan_addr_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [39:0] req_addr = '0;
   logic        resp_valid;
   logic        resp_hit;
   logic [1:0]  resp_chan;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // bench copy of the programmed configuration
   logic [13:0] m_lim [8];
   logic [1:0]  m_mode[8];
   logic        m_en  [8];
   logic [15:0] m_list[8];

   always #2.5 clk = ~clk;

   chan_addr_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .resp_valid(resp_valid), .resp_hit(resp_hit),
      .resp_chan(resp_chan)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(req, cfg_rdata, exp);
   endtask

   task automatic set_rule(input int i, input logic [13:0] lim, input logic [1:0] md,
                           input logic en, input logic [15:0] lst);
      m_lim[i] = lim; m_mode[i] = md; m_en[i] = en; m_list[i] = lst;
      wr(8'(8'h80 + 4*i), {12'd0, lim, 3'd0, md, en});
      wr(8'(8'hC0 + 4*i), {16'd0, lst});
   endtask

   function automatic logic [2:0] ref_idx(input logic [39:0] a, input logic [1:0] md);
      logic [33:0] r;
      r = a[39:6] % 34'd3;
      case (md)
         2'b01:   return a[8:6] ^ a[18:16];
         2'b10:   return {a[6], r[1:0]};
         default: return a[8:6];
      endcase
   endfunction

   // returns {hit, chan}; winner written to w (-1 on miss)
   function automatic logic [2:0] ref_decode(input logic [39:0] a, output int w);
      logic [13:0] k, lo;
      logic [2:0]  ix;
      k = a[39:26];
      w = -1;
      for (int i = 0; i < 8; i++) begin
         lo = (i == 0) ? 14'd0 : m_lim[i-1];
         if (w < 0 && m_en[i] && k >= lo && k < m_lim[i]) w = i;
      end
      if (w < 0) return 3'b000;
      ix = ref_idx(a, m_mode[w]);
      return {1'b1, m_list[w][2*ix +: 2]};
   endfunction

   function automatic string tag_of(input int w);
      if (w < 0) return "R5";
      case (m_mode[w])
         2'b00:   return "R6/R11";
         2'b01:   return "R7/R11";
         2'b10:   return "R8/R11";
         default: return "R9/R11";
      endcase
   endfunction

   task automatic lookup(input logic [39:0] a, input string extra);
      logic [2:0] e;
      int         w;
      e = ref_decode(a, w);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 valid", {31'd0, resp_valid}, 32'd1);
      check({extra, " ", tag_of(w), " R3"}, {29'd0, resp_hit, resp_chan}, {29'd0, e});
   endtask

   task automatic sweep(input int lo_key, input int hi_key, input int per, input string extra);
      for (int k = lo_key; k <= hi_key; k++) begin
         for (int n = 0; n < per; n++) begin
            logic [25:0] low;
            low = 26'($urandom());
            lookup({14'(k), low}, extra);
         end
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_lim[i] = '0; m_mode[i] = '0; m_en[i] = 1'b0; m_list[i] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 8; i++) begin
         rd_check("R1 rule reset", 8'(8'h80 + 4*i), 32'd0);
         rd_check("R1 list reset", 8'(8'hC0 + 4*i), 32'd0);
      end
      lookup(40'h00_0000_1240, "R1 miss after reset");
      @(negedge clk);
      check("R10 valid drops", {31'd0, resp_valid}, 32'd0);

      // R2: field layout and unused bits
      wr(8'h84, 32'hFFFF_FFFF);
      rd_check("R2 rule fields", 8'h84, 32'h000F_FFC7);
      wr(8'hC8, 32'hFFFF_FFFF);
      rd_check("R2 list fields", 8'hC8, 32'h0000_FFFF);
      wr(8'h40, 32'hFFFF_FFFF);
      rd_check("R2 unmapped read", 8'h40, 32'd0);
      rd_check("R2 unmapped write ignored", 8'h80, 32'd0);
      rd_check("R2 unmapped write ignored", 8'hC0, 32'd0);
      rd_check("R2 unmapped write ignored", 8'h84, 32'h000F_FFC7);

      // Layout A: rising bounds, every mode, one disabled hole
      set_rule(0, 14'd2,  2'b00, 1'b1, 16'hE4E4);
      set_rule(1, 14'd4,  2'b01, 1'b1, 16'h1B6C);
      set_rule(2, 14'd6,  2'b10, 1'b1, 16'hD872);
      set_rule(3, 14'd8,  2'b11, 1'b1, 16'h39C6);
      set_rule(4, 14'd10, 2'b00, 1'b0, 16'hFFFF);
      set_rule(5, 14'd12, 2'b10, 1'b1, 16'h4E1B);
      set_rule(6, 14'd14, 2'b01, 1'b1, 16'hB1E4);
      set_rule(7, 14'd16, 2'b00, 1'b0, 16'h5555);
      rd_check("R2 readback", 8'h88, {12'd0, 14'd6, 3'd0, 2'b10, 1'b1});
      rd_check("R2 readback", 8'hC8, 32'h0000_D872);
      sweep(0, 19, 60, "A");
      // R3 boundaries: last key of a window and first key of the next
      lookup({14'd1,  26'h3FF_FFC0}, "R3 top edge");
      lookup({14'd2,  26'h000_0000}, "R3 bottom edge");
      lookup({14'd8,  26'h012_3440}, "R3 disabled hole");
      lookup({14'd14, 26'h0AB_CDC0}, "R3 above last enabled");
      // R8: extra mod-3 coverage
      sweep(4, 5, 400, "R8 mod3");

      // Layout B: non-monotonic bounds, overlap resolved by priority
      set_rule(0, 14'd6, 2'b00, 1'b1, 16'h1E4B);
      set_rule(1, 14'd3, 2'b01, 1'b1, 16'hFFFF);
      set_rule(2, 14'd8, 2'b10, 1'b1, 16'h9C36);
      for (int i = 3; i < 8; i++) set_rule(i, 14'd0, 2'b00, 1'b0, 16'h0000);
      sweep(0, 9, 60, "R4 B");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule